// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Controller

This block is a clocked model of the control section of a byte-wide parallel EEPROM. It samples three active-low strobes (chip select, output enable and write enable), an address and a write-data bus on every clock edge. From these it decodes read, write and idle cycles. A read returns one byte from an internal array one cycle later, and the data bus is enabled only during a read. A write captures its address when the write condition first becomes true and its data on the last cycle the condition holds. Either strobe may be the one that opens and closes the write window.

An accepted write starts a self-timed programming cycle of a fixed number of clock cycles. During that cycle the target byte is not yet updated. A read of the byte being programmed returns the inverse of the new data's top bit, so software can poll for completion. The block refuses a write when the strobe pulse is too short or when the pulse ends with output enable low. It also refuses a write during the power-up hold-off after reset, while the low-supply input is high, and when the pulse began during a programming cycle. Reset also fills the whole array with 0xFF, one byte per cycle, during the power-up hold-off.

Top module: `pee_byte_ctrl`

## Requirements
- R1: While reset is high, `dout_oe` is 0 and `dout` is 0. Once the power-up hold-off has ended, every address reads 0xFF until it is written.
- R2: A read cycle is an edge at which `sel_n`=0, `oe_n`=0 and `we_n`=1. After that edge, `dout_oe` is 1 and `dout` is the addressed byte.
- R3: After any edge that is not a read cycle, `dout_oe` is 0 and `dout` is 0. This includes `sel_n`=0, `oe_n`=0, `we_n`=0, and that combination never writes.
- R4: The write address is taken at the first edge at which `sel_n`=0, `we_n`=0 and `oe_n`=1 all hold. Address changes later in the same pulse have no effect.
- R5: The write data is the value of `din` at the last edge at which the write condition holds.
- R6: A write may be controlled by `we_n` pulsing inside a low `sel_n`, or by `sel_n` pulsing inside a low `we_n`. Both store the byte.
- R7: An accepted write keeps the block busy for exactly WRITE_CYC cycles after the edge at which the pulse ends. The array byte reads the new data from the first read after that window.
- R8: During the busy window, a read of the address being programmed returns {~d[7], 7'b0000000}, where d is the new data. Reads of other addresses return their stored bytes.
- R9: A write pulse held for fewer than MIN_PULSE edges stores nothing.
- R10: A pulse whose write condition ends because `oe_n` went low stores nothing.
- R11: A pulse that ends during the first max(INIT_CYC, 2^ADDR_W) cycles after reset stores nothing.
- R12: A pulse that ends while `supply_low` is 1 stores nothing.
- R13: A pulse whose first write edge falls in a busy window stores nothing, even if the pulse ends after the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clear and hold-off |
| sel_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| supply_low | input | 1 | High while the supply is too low to program |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_oe | output | 1 | High when the block drives the data bus |

## Verification
Every address is written once. Successive addresses alternate between write-enable-controlled and select-controlled pulses, and the pulse lengths cycle through the minimum and two longer values. Each pulse also moves the address after its first edge and changes the data on its last edge, which separates the correct capture points from early or late latching. A read is made on every cycle of each busy window and on the cycle after it. This pins down the exact window length, and it separates polling data from stale or freshly stored data. The refused cases each aim a write at an address whose previous content is known: a pulse one edge too short, an output-enable abort, a write during hold-off, a write under low supply, and a long pulse that begins while busy but ends after the window.

// File: rtl/pee_pkg.sv
package pee_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_READ,
    BUS_WRITE
  } bus_mode_e;

  // Map the three active-low strobes onto a bus cycle type.
  function automatic bus_mode_e decode_bus(input logic sel_n, input logic oe_n,
                                           input logic we_n);
    if (sel_n) return BUS_IDLE;
    if (!oe_n && we_n) return BUS_READ;
    if (oe_n && !we_n) return BUS_WRITE;
    return BUS_IDLE;
  endfunction

endpackage

// File: rtl/pee_init_seq.sv
// Walks every array address after reset, writing the erased value,
// and holds writes off until both the sweep and the hold-off are over.
module pee_init_seq #(
  parameter int ADDR_W   = 11,
  parameter int INIT_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              clr_we,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              ready
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int INIT_TOTAL = (INIT_CYC > DEPTH) ? INIT_CYC : DEPTH;
  localparam int CNT_W      = $clog2(INIT_TOTAL + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt != CNT_W'(INIT_TOTAL)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    clr_we   = !rst && (cnt < CNT_W'(DEPTH));
    clr_addr = cnt[ADDR_W-1:0];
    ready    = (cnt == CNT_W'(INIT_TOTAL));
  end
endmodule

// File: rtl/pee_strobe_latch.sv
// Tracks one write pulse: address at its opening edge, data at its last
// edge, pulse length, and whether it began outside a busy window.
module pee_strobe_latch
  import pee_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  input  logic              allow,
  output logic              start,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);

  logic             wr_act;
  logic             was_act;
  logic             armed;
  logic [CNT_W-1:0] run;

  assign wr_act = (decode_bus(sel_n, oe_n, we_n) == BUS_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      was_act  <= 1'b0;
      armed    <= 1'b0;
      run      <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      was_act <= wr_act;
      if (wr_act) cap_data <= din;
      if (wr_act && !was_act) begin
        cap_addr <= addr;
        armed    <= !busy;
        run      <= CNT_W'(1);
      end else if (wr_act && run != CNT_W'(MIN_PULSE)) begin
        run <= run + 1'b1;
      end
    end
  end

  // The pulse closes cleanly only when a strobe rose while oe_n stayed high.
  assign start = was_act && !wr_act && oe_n && armed &&
                 (run == CNT_W'(MIN_PULSE)) && allow;
endmodule

// File: rtl/pee_write_timer.sv
// Self-timed programming window; the byte is committed on its last cycle.
module pee_write_timer #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int WRITE_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              prog_we,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  localparam int TMR_W = $clog2(WRITE_CYC);

  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      tmr       <= '0;
      prog_addr <= '0;
      prog_data <= '0;
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - 1'b1;
    end else if (start) begin
      busy      <= 1'b1;
      tmr       <= TMR_W'(WRITE_CYC - 1);
      prog_addr <= addr;
      prog_data <= data;
    end
  end

  assign prog_we = busy && (tmr == '0);
endmodule

// File: rtl/pee_byte_array.sv
// Single-port-write, registered-read storage suitable for block RAM.
module pee_byte_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pee_byte_ctrl.sv
module pee_byte_ctrl
  import pee_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int WRITE_CYC = 500000,
  parameter int INIT_CYC  = 250000,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  logic              clr_we, ready;
  logic [ADDR_W-1:0] clr_addr;
  logic              wr_start, wr_busy, prog_we;
  logic [ADDR_W-1:0] cap_addr, prog_addr;
  logic [DATA_W-1:0] cap_data, prog_data;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_q;
  logic              rd_oe_q, poll_q;
  logic [DATA_W-1:0] poll_val_q;

  pee_init_seq #(.ADDR_W(ADDR_W), .INIT_CYC(INIT_CYC)) u_init (
    .clk(clk), .rst(rst), .clr_we(clr_we), .clr_addr(clr_addr), .ready(ready)
  );

  pee_strobe_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
    .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(wr_busy), .allow(ready && !supply_low),
    .start(wr_start), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  pee_write_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYC(WRITE_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(wr_start), .addr(cap_addr), .data(cap_data),
    .busy(wr_busy), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data)
  );

  // The clear sweep and a programming commit never overlap: commits need ready.
  always_comb begin
    mem_we    = clr_we || prog_we;
    mem_waddr = clr_we ? clr_addr : prog_addr;
    mem_wdata = clr_we ? {DATA_W{1'b1}} : prog_data;
  end

  pee_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr), .rdata(mem_q)
  );

  // Polling decision is registered beside the array read so both line up.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe_q    <= 1'b0;
      poll_q     <= 1'b0;
      poll_val_q <= '0;
    end else begin
      rd_oe_q    <= (decode_bus(sel_n, oe_n, we_n) == BUS_READ);
      poll_q     <= wr_busy && (addr == prog_addr);
      poll_val_q <= {~prog_data[DATA_W-1], {(DATA_W-1){1'b0}}};
    end
  end

  assign dout_oe = rd_oe_q;
  assign dout    = rd_oe_q ? (poll_q ? poll_val_q : mem_q) : '0;
endmodule

// File: rtl/pee_byte_ctrl_chk.sv
module pee_byte_ctrl_chk #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int WRITE_CYC = 500000,
  parameter int INIT_CYC  = 250000,
  parameter int MIN_PULSE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              supply_low,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              busy,
  input logic              start
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int INIT_TOTAL = (INIT_CYC > DEPTH) ? INIT_CYC : DEPTH;

  int unsigned since_rst;
  int unsigned busy_len;
  int unsigned pulse_len;
  logic        wcond;

  assign wcond = !sel_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 0;
      busy_len  <= 0;
      pulse_len <= 0;
    end else begin
      if (since_rst != INIT_TOTAL) since_rst <= since_rst + 1;
      busy_len <= busy ? busy_len + 1 : 0;
      if (!wcond) pulse_len <= 0;
      else if (pulse_len != MIN_PULSE) pulse_len <= pulse_len + 1;
    end
  end

  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !oe_n && we_n) |=> dout_oe);

  p_float_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_n || oe_n || !we_n) |=> !dout_oe);

  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> (dout == '0));

  p_busy_window_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == WRITE_CYC));

  p_min_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> (pulse_len >= MIN_PULSE));

  p_holdoff_r11: assert property (@(posedge clk) disable iff (rst)
    start |-> (since_rst == INIT_TOTAL));

  p_low_supply_r12: assert property (@(posedge clk) disable iff (rst)
    start |-> !supply_low);

  p_no_restart_r13: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

bind pee_byte_ctrl pee_byte_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYC(WRITE_CYC),
  .INIT_CYC(INIT_CYC), .MIN_PULSE(MIN_PULSE)
) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
  .supply_low(supply_low), .dout(dout), .dout_oe(dout_oe),
  .busy(wr_busy), .start(wr_start)
);

// File: tb/test_pee_byte_ctrl.sv
module test_pee_byte_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WC = 6;
  localparam int IC = 20;
  localparam int MP = 3;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] shadow [NB];

  always #10 clk = ~clk;

  pee_byte_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYC(WC), .INIT_CYC(IC),
                  .MIN_PULSE(MP)) i_pee_byte_ctrl (
    .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
    .supply_low(supply_low), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] poll_of(logic [7:0] d);
    return {~d[7], 7'b0000000};
  endfunction

  task automatic check(string req, logic exp_oe, logic [7:0] exp);
    checks++;
    if (dout_oe !== exp_oe || dout !== exp) begin
      errors++;
      $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
               req, dout_oe, dout, exp_oe, exp);
    end
  endtask

  task automatic idle(int n);
    sel_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(int a);
    sel_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    @(negedge clk);
  endtask

  // One write pulse of len sampled edges; address moves after the first edge,
  // data becomes d only on the last edge. abort ends the pulse with oe_n low.
  task automatic wr(int a, logic [7:0] d, int len, bit ce_ctl, bit abort);
    addr = AW'(a); din = ~d; oe_n = 1'b1;
    if (ce_ctl) begin we_n = 1'b0; sel_n = 1'b1; end
    else        begin sel_n = 1'b0; we_n = 1'b1; end
    @(negedge clk);
    if (ce_ctl) sel_n = 1'b0; else we_n = 1'b0;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (i == 1) addr = ~AW'(a);
      if (i == len - 1) din = d;
    end
    @(negedge clk);
    if (abort) oe_n = 1'b0;
    else if (ce_ctl) sel_n = 1'b1;
    else we_n = 1'b1;
    @(negedge clk);
    idle(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 8'h00);
    rst = 1'b0;
    // R11: pulse inside the hold-off must not store
    wr(3, 8'h12, MP, 1'b0, 1'b0);
    idle(30);
    for (int a = 0; a < NB; a++) begin
      rd(a);
      check(a == 3 ? "R11 hold-off" : "R1/R2 erased read", 1'b1, 8'hFF);
      shadow[a] = 8'hFF;
    end
    idle(1);
    // R3: non-read combinations float the bus
    sel_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; @(negedge clk);
    check("R3 sel high", 1'b0, 8'h00);
    sel_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; @(negedge clk);
    check("R3 oe high", 1'b0, 8'h00);
    sel_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 4'd1; din = 8'h00;
    repeat (MP + 1) @(negedge clk);
    check("R3 all low", 1'b0, 8'h00);
    idle(WC + 2);
    // Sweep: every address, alternating control strobe and pulse length
    for (int a = 0; a < NB; a++) begin
      logic [7:0] d;
      d = pat(a);
      wr(a, d, MP + (a % 3), bit'(a % 2), 1'b0);
      for (int j = 1; j <= WC + 1; j++) begin
        rd(a);
        if (j <= WC) check("R8 polling", 1'b1, poll_of(d));
        else check((a % 2) ? "R7/R6 select-driven/R4/R5" : "R7/R6 we-driven/R4/R5",
                   1'b1, d);
      end
      shadow[a] = d;
      idle(1);
    end
    // R8: other addresses read true data during busy
    wr(9, 8'h19, MP, 1'b0, 1'b0);
    rd(9);  check("R8 target", 1'b1, 8'h80);
    rd(4);  check("R8 other address", 1'b1, shadow[4]);
    idle(WC + 2);
    rd(9);  check("R7 after busy", 1'b1, 8'h19);
    shadow[9] = 8'h19;
    idle(1);
    // R13: long pulse opening while busy, closing after the window
    wr(2, 8'h3C, MP, 1'b0, 1'b0);
    wr(5, 8'hAA, MP + 3, 1'b1, 1'b0);
    idle(WC + 2);
    rd(5);  check("R13 ignored", 1'b1, shadow[5]);
    rd(2);  check("R13 first write", 1'b1, 8'h3C);
    shadow[2] = 8'h3C;
    idle(1);
    // R9: one edge too short
    wr(6, 8'h11, MP - 1, 1'b0, 1'b0);
    idle(WC + 2);
    rd(6);  check("R9 short pulse", 1'b1, shadow[6]);
    idle(1);
    // R10: output enable abort
    wr(7, 8'h22, MP, 1'b0, 1'b1);
    idle(WC + 2);
    rd(7);  check("R10 oe abort", 1'b1, shadow[7]);
    idle(1);
    // R12: low supply
    supply_low = 1'b1;
    wr(8, 8'h33, MP, 1'b1, 1'b0);
    supply_low = 1'b0;
    idle(WC + 2);
    rd(8);  check("R12 low supply", 1'b1, shadow[8]);
    idle(1);
    for (int a = 0; a < NB; a++) begin
      rd(a);
      check("R7 final contents", 1'b1, shadow[a]);
    end
    idle(1);
    check("R3 idle", 1'b0, 8'h00);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule